// File: doc/BRIEF.md
# Load-Reserve Snooping Reservation Tracker

This block keeps the single atomic-access reservation of one processor. The local side presents load-reserve and store-conditional requests on one request port. An accepted load-reserve is turned into a bus read request whose transaction type follows from the 3-bit storage attribute of the access. From the moment the bus acknowledges that address tenure, the block watches the address tenures of other masters. Any flushing write to the same 32-byte granule destroys the reservation. The window includes the stretch where the reserved load's own data has not yet returned.

Each store-conditional gets a one-cycle pass/fail answer and always consumes the reservation. A `rsrv_held` output tells an external second-level cache that a reservation is live, so that the cache can filter snoops on its own side. That output rises only after the address acknowledge. A context-switch clear input discards the reservation at any point of its life.

The controller is a six-state machine:
- `ST_IDLE`: no reservation.
- `ST_ADDR`: the address tenure is requested and the reservation is still wanted.
- `ST_ADDR_VOID`: the address tenure is requested but the reservation was abandoned.
- `ST_DATA`: the reservation is live and the data is still outstanding.
- `ST_HELD`: the reservation is live and the data has returned.
- `ST_DRAIN`: the data is outstanding but no reservation exists.

Named transitions:
- issue: `ST_IDLE`/`ST_HELD` to `ST_ADDR`.
- arm: `ST_ADDR` to `ST_DATA` on acknowledge.
- void: `ST_ADDR` to `ST_ADDR_VOID` on clear.
- late-arm: `ST_ADDR_VOID` to `ST_DRAIN`, or `ST_ADDR` to `ST_DRAIN` when clear and acknowledge coincide.
- fill: `ST_DATA` to `ST_HELD`.
- lose: `ST_DATA` to `ST_DRAIN`/`ST_IDLE`, or `ST_HELD` to `ST_IDLE`, on a kill, clear or store-conditional.
- drain: `ST_DRAIN` to `ST_IDLE` on data return.

Top module: `rsv_tracker`

## Requirements
- R1: During and after a synchronous reset, `rsrv_held`, `bus_req`, `sc_done` and `sc_pass` are 0 and `bus_ttype` is 2'b00.
- R2: The attribute is `req_attr` = {write-through, cache-inhibit, coherent} as bits [2:0]. Codes 011 and 111 (noncacheable) request a read-atomic, `bus_ttype` 2'b10. Codes 001 and 101 (write-back, write-through) request a plain read, `bus_ttype` 2'b01. Any other code makes the load-reserve be ignored, with no `bus_req`.
- R3: A load-reserve (`req_valid`=1, `req_is_sc`=0) is accepted only when no load-reserve is outstanding (states `ST_IDLE`, `ST_HELD`). It raises `bus_req` from the next cycle up to and including the cycle of `bus_addr_ack`, with `bus_addr` equal to the request address. A load-reserve that arrives while one is outstanding is ignored.
- R4: `rsrv_held` is 1 from the cycle after `bus_addr_ack` of a live load-reserve. It stays 1 through data return (`bus_data_done`) until the reservation is lost. It is never 1 before the acknowledge.
- R5: `snp_kind` is coded 00 read, 01 read-atomic, 10 write-with-flush, 11 write-with-flush atomic. A snoop (`snp_valid`=1) of kind 10 or 11 whose granule matches clears the reservation when it comes in any cycle after the acknowledge cycle, including cycles before data return. Reads, and snoops before or in the acknowledge cycle, leave it intact.
- R6: Address comparison ignores address bits [GRAN_LSB-1:0] (default 5, a 32-byte granule).
- R7: A store-conditional (`req_valid`=1, `req_is_sc`=1) in any state gives `sc_done`=1 in the next cycle. `sc_pass` is 1 only if a reservation was live and its granule matched, with no kill and no clear in the same cycle. The reservation is gone afterwards either way.
- R8: A load-reserve while a reservation is held replaces it: `rsrv_held` drops and the new address is requested. If a matching kill arrives in the same cycle, the new load-reserve is still accepted.
- R9: `ctx_clear` removes the reservation in any state. If it arrives before the acknowledge, the pending load-reserve completes its bus tenure without ever raising `rsrv_held`.
- R10: A matching kill in the same cycle as `bus_data_done` leaves no reservation, and the block returns to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctx_clear | input | 1 | Context-switch clear of the reservation |
| req_valid | input | 1 | Local request present |
| req_is_sc | input | 1 | 1 = store-conditional, 0 = load-reserve |
| req_addr | input | ADDR_W | Request address |
| req_attr | input | 3 | Storage attribute of the request |
| bus_req | output | 1 | Load-reserve address tenure requested |
| bus_ttype | output | 2 | Transaction type: 01 read, 10 read-atomic, 00 none |
| bus_addr | output | ADDR_W | Address of the load-reserve tenure |
| bus_addr_ack | input | 1 | Address acknowledge of this block's tenure |
| bus_data_done | input | 1 | Data phase of the load-reserve completed |
| snp_valid | input | 1 | Snooped address tenure present |
| snp_kind | input | 2 | Snooped transaction kind |
| snp_addr | input | ADDR_W | Snooped address |
| rsrv_held | output | 1 | Reservation live |
| sc_done | output | 1 | Store-conditional answer strobe |
| sc_pass | output | 1 | Store-conditional succeeded |

## Verification
The critical coincidence is a snooped flushing write landing in the same cycle as another reservation event. The other event may be the acknowledge, the data return, a store-conditional or a new load-reserve. The bench walks one reservation through all four life phases and places a snoop of each kind, matching or not, in each phase. This includes the acknowledge cycle itself and the gap before data return. It then judges survival from `rsrv_held` and from the outcome of a store-conditional. Separate cases put a kill together with a store-conditional, with a replacing load-reserve and with data return. The expected result of each case comes from the priority rules in R5, R7, R8 and R10.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ADDR      = 3'd1,
        ST_ADDR_VOID = 3'd2,
        ST_DATA      = 3'd3,
        ST_HELD      = 3'd4,
        ST_DRAIN     = 3'd5
    } rsv_state_e;

    typedef enum logic [1:0] {
        TT_NONE        = 2'b00,
        TT_READ        = 2'b01,
        TT_READ_ATOMIC = 2'b10
    } bus_tt_e;

    localparam logic [1:0] SNP_WFLUSH        = 2'b10;
    localparam logic [1:0] SNP_WFLUSH_ATOMIC = 2'b11;

    typedef struct packed {
        logic legal;
        logic noncache;
    } attr_class_t;
endpackage

// File: rtl/rsv_attr_decode.sv
module rsv_attr_decode
    import rsv_pkg::*;
(
    input  logic [2:0]  attr,
    output attr_class_t cls
);
    always_comb begin
        cls = '0;
        unique case (attr)
            3'b011, 3'b111: begin
                cls.legal    = 1'b1;
                cls.noncache = 1'b1;
            end
            3'b001, 3'b101: begin
                cls.legal    = 1'b1;
                cls.noncache = 1'b0;
            end
            default: cls = '0;
        endcase
    end
endmodule

// File: rtl/rsv_granule_cmp.sv
module rsv_granule_cmp #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 5
) (
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] GMASK =
        {{(ADDR_W-GRAN_LSB){1'b1}}, {GRAN_LSB{1'b0}}};

    always_comb begin
        hit = (((ref_addr ^ probe_addr) & GMASK) == '0);
    end
endmodule

// File: rtl/rsv_fsm.sv
module rsv_fsm
    import rsv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctx,
    input  logic       lr_go,
    input  logic       sc_go,
    input  logic       ack,
    input  logic       done,
    input  logic       kill_hit,
    input  logic       sc_hit,
    output rsv_state_e st,
    output logic       capture,
    output logic       sc_done_q,
    output logic       sc_pass_q
);
    rsv_state_e nxt;
    logic       live;
    logic       kill;
    logic       pass;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    // transitions
    always_comb begin
        nxt     = st;
        capture = 1'b0;
        live    = (st == ST_DATA) || (st == ST_HELD);
        kill    = kill_hit && live;
        pass    = sc_go && live && sc_hit && !kill && !ctx;
        unique case (st)
            ST_IDLE: begin
                if (lr_go) begin
                    nxt     = ST_ADDR;       // issue
                    capture = 1'b1;
                end
            end
            ST_ADDR: begin
                if (ctx)      nxt = ack ? ST_DRAIN : ST_ADDR_VOID; // void / late-arm
                else if (ack) nxt = ST_DATA;                       // arm
            end
            ST_ADDR_VOID: begin
                if (ack) nxt = ST_DRAIN;                           // late-arm
            end
            ST_DATA: begin
                if (ctx || kill || sc_go) nxt = done ? ST_IDLE : ST_DRAIN; // lose
                else if (done)            nxt = ST_HELD;                  // fill
            end
            ST_HELD: begin
                if (lr_go) begin
                    nxt     = ST_ADDR;                                    // issue
                    capture = 1'b1;
                end else if (ctx || kill || sc_go) begin
                    nxt = ST_IDLE;                                        // lose
                end
            end
            ST_DRAIN: begin
                if (done) nxt = ST_IDLE;                                  // drain
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sc_done_q <= 1'b0;
            sc_pass_q <= 1'b0;
        end else begin
            sc_done_q <= sc_go;
            sc_pass_q <= pass;
        end
    end
endmodule

// File: rtl/rsv_tracker.sv
module rsv_tracker
    import rsv_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctx_clear,
    input  logic              req_valid,
    input  logic              req_is_sc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_attr,
    output logic              bus_req,
    output logic [1:0]        bus_ttype,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_addr_ack,
    input  logic              bus_data_done,
    input  logic              snp_valid,
    input  logic [1:0]        snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              rsrv_held,
    output logic              sc_done,
    output logic              sc_pass
);
    localparam int NCMP = 2;   // 0: snoop probe, 1: store-conditional probe

    attr_class_t       cls;
    rsv_state_e        st;
    logic              capture;
    logic              lr_go;
    logic              sc_go;
    logic              snp_write;
    logic [ADDR_W-1:0] res_addr;
    logic              res_nc;
    logic [ADDR_W-1:0] probe [NCMP];
    logic [NCMP-1:0]   hit;

    rsv_attr_decode u_dec (
        .attr (req_attr),
        .cls  (cls)
    );

    always_comb begin
        lr_go     = req_valid && !req_is_sc && cls.legal;
        sc_go     = req_valid && req_is_sc;
        snp_write = snp_valid &&
                    ((snp_kind == SNP_WFLUSH) || (snp_kind == SNP_WFLUSH_ATOMIC));
        probe[0]  = snp_addr;
        probe[1]  = req_addr;
    end

    for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
        rsv_granule_cmp #(
            .ADDR_W   (ADDR_W),
            .GRAN_LSB (GRAN_LSB)
        ) u_cmp (
            .ref_addr   (res_addr),
            .probe_addr (probe[gi]),
            .hit        (hit[gi])
        );
    end

    rsv_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctx       (ctx_clear),
        .lr_go     (lr_go),
        .sc_go     (sc_go),
        .ack       (bus_addr_ack),
        .done      (bus_data_done),
        .kill_hit  (snp_write && hit[0]),
        .sc_hit    (hit[1]),
        .st        (st),
        .capture   (capture),
        .sc_done_q (sc_done),
        .sc_pass_q (sc_pass)
    );

    // reservation register
    always_ff @(posedge clk) begin
        if (rst) begin
            res_addr <= '0;
            res_nc   <= 1'b0;
        end else if (capture) begin
            res_addr <= req_addr;
            res_nc   <= cls.noncache;
        end
    end

    always_comb begin
        bus_req   = (st == ST_ADDR) || (st == ST_ADDR_VOID);
        bus_ttype = !bus_req ? TT_NONE : (res_nc ? TT_READ_ATOMIC : TT_READ);
        bus_addr  = res_addr;
        rsrv_held = (st == ST_DATA) || (st == ST_HELD);
    end
endmodule

// File: rtl/rsv_tracker_chk.sv
module rsv_tracker_chk #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              ctx_clear,
    input logic              req_valid,
    input logic              req_is_sc,
    input logic              bus_req,
    input logic [1:0]        bus_ttype,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_addr_ack,
    input logic              snp_valid,
    input logic [1:0]        snp_kind,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              rsrv_held,
    input logic              sc_done,
    input logic              sc_pass
);
    localparam logic [ADDR_W-1:0] CMASK =
        {{(ADDR_W-GRAN_LSB){1'b1}}, {GRAN_LSB{1'b0}}};

    logic snoop_kill_seen;
    always_comb begin
        snoop_kill_seen = snp_valid && (snp_kind == 2'b10 || snp_kind == 2'b11) &&
                          (((bus_addr ^ snp_addr) & CMASK) == '0);
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!rsrv_held && !bus_req && !sc_done && !sc_pass)); // R1
    AST_TTYPE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_ttype == 2'b01 || bus_ttype == 2'b10)); // R2
    AST_TENURE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && $past(bus_req)) |-> ($stable(bus_ttype) && $stable(bus_addr))); // R3
    AST_HOLD_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(rsrv_held) |-> $past(bus_addr_ack)); // R4
    AST_SNOOP_KILL: assert property (@(posedge clk) disable iff (rst)
        (rsrv_held && snoop_kill_seen && !(req_valid && !req_is_sc)) |=> !rsrv_held); // R5
    AST_SC_ANSWER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_sc) |=> sc_done); // R7
    AST_SC_PASS_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        sc_pass |-> (sc_done && $past(rsrv_held))); // R7
    AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_sc && !bus_addr_ack) |=> !rsrv_held); // R7
    AST_CTX_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ctx_clear |=> !rsrv_held); // R9
endmodule

bind rsv_tracker rsv_tracker_chk #(
    .ADDR_W   (ADDR_W),
    .GRAN_LSB (GRAN_LSB)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctx_clear    (ctx_clear),
    .req_valid    (req_valid),
    .req_is_sc    (req_is_sc),
    .bus_req      (bus_req),
    .bus_ttype    (bus_ttype),
    .bus_addr     (bus_addr),
    .bus_addr_ack (bus_addr_ack),
    .snp_valid    (snp_valid),
    .snp_kind     (snp_kind),
    .snp_addr     (snp_addr),
    .rsrv_held    (rsrv_held),
    .sc_done      (sc_done),
    .sc_pass      (sc_pass)
);

// File: tb/tb_rsv_tracker.sv
`timescale 1ns/1ps
module tb_rsv_tracker;
    localparam int AW = 32;
    localparam logic [AW-1:0] BASE = 32'h0000_1240;
    localparam logic [AW-1:0] OTHER = 32'h0000_5300;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctx_clear = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_is_sc = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_attr = '0;
    logic          bus_req;
    logic [1:0]    bus_ttype;
    logic [AW-1:0] bus_addr;
    logic          bus_addr_ack = 1'b0;
    logic          bus_data_done = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_kind = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          rsrv_held;
    logic          sc_done;
    logic          sc_pass;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rsv_tracker #(.ADDR_W(AW), .GRAN_LSB(5)) dut (
        .clk(clk), .rst(rst), .ctx_clear(ctx_clear),
        .req_valid(req_valid), .req_is_sc(req_is_sc), .req_addr(req_addr), .req_attr(req_attr),
        .bus_req(bus_req), .bus_ttype(bus_ttype), .bus_addr(bus_addr),
        .bus_addr_ack(bus_addr_ack), .bus_data_done(bus_data_done),
        .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
        .rsrv_held(rsrv_held), .sc_done(sc_done), .sc_pass(sc_pass)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        ctx_clear = 0; req_valid = 0; req_is_sc = 0; bus_addr_ack = 0;
        bus_data_done = 0; snp_valid = 0; snp_kind = 0;
    endtask

    // apply current inputs at the next edge, then sample 1 ns later
    task automatic step();
        @(posedge clk);
        #1;
        idle_in();
    endtask

    task automatic do_reset();
        idle_in();
        rst = 1; step(); step(); rst = 0;
    endtask

    task automatic put_lr(input logic [AW-1:0] a, input logic [2:0] at);
        req_valid = 1; req_is_sc = 0; req_addr = a; req_attr = at;
    endtask

    task automatic put_sc(input logic [AW-1:0] a);
        req_valid = 1; req_is_sc = 1; req_addr = a;
    endtask

    task automatic put_snp(input logic [1:0] k, input logic [AW-1:0] a);
        snp_valid = 1; snp_kind = k; snp_addr = a;
    endtask

    task automatic establish(input logic [AW-1:0] a);
        put_lr(a, 3'b001); step();
        bus_addr_ack = 1; step();
        bus_data_done = 1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (R1..R10 run): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 rsrv_held", rsrv_held, 0);
        chk("R1 bus_req", bus_req, 0);
        chk("R1 bus_ttype", bus_ttype, 0);
        chk("R1 sc_done", sc_done, 0);
        chk("R1 sc_pass", sc_pass, 0);

        // R2 attribute sweep
        for (int at = 0; at < 8; at++) begin
            logic [2:0] a3;
            logic legal, nc;
            a3 = at[2:0];
            nc = a3[1] & a3[0];
            legal = nc | (a3[1:0] == 2'b01);
            do_reset();
            put_lr(BASE, a3); step();
            chk("R2 bus_req", bus_req, legal);
            chk("R2 bus_ttype", bus_ttype, legal ? (nc ? 2 : 1) : 0);
            if (legal) chk("R3 bus_addr", bus_addr, BASE);
        end

        // R3/R4: request held until ack, no reservation before it, ignored repeat load
        do_reset();
        put_lr(BASE, 3'b011); step();
        step();
        chk("R3 bus_req holds", bus_req, 1);
        chk("R4 no hold before ack", rsrv_held, 0);
        put_lr(OTHER, 3'b001); step();
        chk("R3 repeat ignored addr", bus_addr, BASE);
        bus_addr_ack = 1; step();
        chk("R3 bus_req drops", bus_req, 0);
        chk("R4 held after ack", rsrv_held, 1);
        put_lr(OTHER, 3'b001); step();
        chk("R3 load ignored in data wait", bus_req, 0);
        bus_data_done = 1; step();
        chk("R4 held after data", rsrv_held, 1);
        put_sc(BASE); step();
        chk("R7 sc pass", sc_pass, 1);
        chk("R7 sc done", sc_done, 1);
        step();
        chk("R7 sc consumes", rsrv_held, 0);
        chk("R7 sc done single", sc_done, 0);

        // R5 snoop window sweep: phase 0 addr, 1 ack cycle, 2 data wait, 3 held
        for (int ph = 0; ph < 4; ph++) begin
            for (int k = 0; k < 4; k++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [AW-1:0] sa;
                    logic killed;
                    sa = m ? (BASE ^ 32'h1F) : (BASE + 32'd32);
                    killed = k[1] && m && (ph >= 2);
                    do_reset();
                    put_lr(BASE, 3'b101); step();
                    if (ph == 0) begin put_snp(k[1:0], sa); step(); end
                    bus_addr_ack = 1;
                    if (ph == 1) put_snp(k[1:0], sa);
                    step();
                    if (ph == 2) begin put_snp(k[1:0], sa); step(); end
                    bus_data_done = 1; step();
                    if (ph == 3) begin put_snp(k[1:0], sa); step(); end
                    chk("R5 held after snoop", rsrv_held, !killed);
                    put_sc(BASE); step();
                    chk("R5 sc result after snoop", sc_pass, !killed);
                end
            end
        end

        // R6 granule sweep for store-conditional address
        for (int off = -64; off <= 64; off += 8) begin
            logic [AW-1:0] sa;
            sa = BASE + off;
            do_reset();
            establish(BASE);
            put_sc(sa); step();
            chk("R6 granule match", sc_pass, (sa >> 5) == (BASE >> 5));
        end

        // R7 sc without reservation fails and still answers
        do_reset();
        put_sc(BASE); step();
        chk("R7 sc idle done", sc_done, 1);
        chk("R7 sc idle fail", sc_pass, 0);

        // R7 kill and sc in the same cycle
        do_reset();
        establish(BASE);
        put_sc(BASE); put_snp(2'b11, BASE); step();
        chk("R7 sc with kill fails", sc_pass, 0);

        // R8 replacement with kill in the same cycle
        do_reset();
        establish(BASE);
        put_lr(OTHER, 3'b011); put_snp(2'b10, BASE); step();
        chk("R8 old dropped", rsrv_held, 0);
        chk("R8 new requested", bus_req, 1);
        chk("R8 new addr", bus_addr, OTHER);
        chk("R8 new ttype", bus_ttype, 2);
        bus_addr_ack = 1; step();
        bus_data_done = 1; step();
        put_sc(OTHER); step();
        chk("R8 new reservation passes", sc_pass, 1);

        // R9 ctx_clear in held state, data wait, and before ack
        do_reset();
        establish(BASE);
        ctx_clear = 1; step();
        chk("R9 clear held", rsrv_held, 0);
        do_reset();
        put_lr(BASE, 3'b001); step();
        bus_addr_ack = 1; step();
        ctx_clear = 1; step();
        chk("R9 clear data wait", rsrv_held, 0);
        bus_data_done = 1; step();
        put_sc(BASE); step();
        chk("R9 sc after clear fails", sc_pass, 0);
        do_reset();
        put_lr(BASE, 3'b001); step();
        ctx_clear = 1; step();
        chk("R9 tenure kept", bus_req, 1);
        bus_addr_ack = 1; step();
        chk("R9 no hold after voided ack", rsrv_held, 0);
        bus_data_done = 1; step();
        chk("R9 still no hold", rsrv_held, 0);

        // R10 kill with data return
        do_reset();
        put_lr(BASE, 3'b001); step();
        bus_addr_ack = 1; step();
        bus_data_done = 1; put_snp(2'b10, BASE + 4); step();
        chk("R10 no hold", rsrv_held, 0);
        put_lr(OTHER, 3'b001); step();
        chk("R10 back in idle", bus_req, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule